// File: doc/BRIEF.md
# SPI Configuration Session Sequencer

This block runs a complete configuration session against a target device that listens on a byte-wide SPI master. A single start pulse launches a fixed script. The script first sends an enable command and fetches a four-byte result, which must be zero. It then switches the target into program mode and streams the image as fixed-size frames. It ends with a disable command, a settling pause and a release command. Image bytes arrive on a valid/ready byte stream. The serial shifter is a separate block. It exchanges one byte on every accepted transfer and returns the received byte in the same cycle.

Before every chip-select transaction the sequencer asks an external status poller whether the target is idle and waits for its answer. A refused answer ends the session. Requests for partial reconfiguration, and image lengths that are not a whole number of frames, are refused before any traffic starts. The outputs are a done pulse, an error pulse and a program-mode flag.

Top module: `spi_cfg_seq`

## Requirements
- R1: When a start pulse arrives with `partial_i` high, `err_o` pulses on the next cycle. No poll request and no chip-select follow.
- R2: When a start pulse arrives with a length that is not a multiple of 16 bytes, `err_o` pulses on the next cycle. No poll request and no chip-select follow.
- R3: Every chip-select transaction is preceded by one poll request. The request is held until `poll_ack_i`. Chip-select rises only after an acknowledge that carries `poll_ok_i` high.
- R4: `poll_need_ready_o` is high only during the poll that comes before the read-back transaction, which is the second poll of a session.
- R5: The first transaction is the single byte 0x0B. The second is 0x01 followed by four filler bytes 0x00, and the bytes received during those four fillers form the result.
- R6: A nonzero byte anywhere in the four-byte result ends the session with an error pulse. No further transaction follows.
- R7: The third transaction is 0xAE then 0x01. `prog_mode_o` is high from the end of that transaction onward.
- R8: Each frame is its own transaction: 0xEE followed by 16 image bytes in stream order. There are length/16 frames, and none for a zero length. Gaps in the image stream or in SPI readiness hold the transaction open without losing bytes.
- R9: After the frames, the single byte 0x0C is sent. Chip-select then stays low for at least CLK_HZ/1000 cycles. After that the single byte 0x23 is sent.
- R10: After the release byte, `done_o` pulses for one cycle and `prog_mode_o` is low from that cycle on. `done_o` and `err_o` are never high together.
- R11: An acknowledge with `poll_ok_i` low makes `err_o` pulse on the next cycle. It also returns the block to idle with chip-select and poll request low and `prog_mode_o` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start pulse, taken in idle |
| partial_i | input | 1 | Partial reconfiguration request, sampled with start |
| img_len_i | input | LEN_W | Image length in bytes, sampled with start |
| img_valid_i | input | 1 | Image byte valid |
| img_data_i | input | 8 | Image byte |
| img_ready_o | output | 1 | Image byte consumed |
| poll_req_o | output | 1 | Request to the status poller |
| poll_need_ready_o | output | 1 | Poll must also see the ready flag |
| poll_ack_i | input | 1 | Poller answer strobe |
| poll_ok_i | input | 1 | Poller answer: condition met |
| spi_cs_o | output | 1 | Chip-select active |
| spi_tx_valid_o | output | 1 | Byte to send is valid |
| spi_tx_data_o | output | 8 | Byte to send |
| spi_tx_ready_i | input | 1 | Shifter takes the byte this cycle |
| spi_rx_data_i | input | 8 | Byte received in the same exchange |
| prog_mode_o | output | 1 | Target is in program mode |
| done_o | output | 1 | Session finished, one-cycle pulse |
| err_o | output | 1 | Session refused or aborted, one-cycle pulse |

## Verification
One case needs care: a poller refusal that lands right after program mode has been entered. In that cycle the error pulse and the clearing of the program-mode flag must both take effect. The bench provokes this by refusing the fourth poll of a session, the one that guards the first frame. It then requires exactly three completed transactions, one error pulse, no done pulse and the flag low afterwards. Stalled image and SPI handshakes are mixed into other sessions, and each one must still produce byte-exact frames.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam logic [7:0] OP_ENABLE  = 8'h0B;
  localparam logic [7:0] OP_DISABLE = 8'h0C;
  localparam logic [7:0] OP_RDDATA  = 8'h01;
  localparam logic [7:0] OP_PGM_HI  = 8'hAE;
  localparam logic [7:0] OP_PGM_LO  = 8'h01;
  localparam logic [7:0] OP_FRAME   = 8'hEE;
  localparam logic [7:0] OP_RELEASE = 8'h23;
  localparam logic [7:0] OP_FILL    = 8'h00;
  localparam int unsigned RB_BYTES  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_XFER, ST_GAP, ST_SETTLE
  } step_e;

  typedef enum logic [2:0] {
    PH_EN, PH_RD, PH_PGM, PH_FRM, PH_DIS, PH_REL
  } phase_e;
endpackage

// File: rtl/spi_cfg_settle_timer.sv
module spi_cfg_settle_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q <= CW'(CYCLES - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  a_r9_done_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(run_q));
endmodule

// File: rtl/spi_cfg_frame_ctr.sv
module spi_cfg_frame_ctr #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (dec_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == W'(1));

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/spi_cfg_cmd_rom.sv
module spi_cfg_cmd_rom
  import spi_cfg_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 16,
  parameter int unsigned IDX_W       = 5
) (
  input  phase_e           phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       img_data_i,
  output logic [7:0]       byte_o,
  output logic [IDX_W-1:0] len_o,
  output logic             is_data_o
);
  logic first;
  assign first = (idx_i == '0);

  always_comb begin
    byte_o    = OP_FILL;
    len_o     = IDX_W'(1);
    is_data_o = 1'b0;
    unique case (phase_i)
      PH_EN:  byte_o = OP_ENABLE;
      PH_RD: begin
        byte_o = first ? OP_RDDATA : OP_FILL;
        len_o  = IDX_W'(RB_BYTES + 1);
      end
      PH_PGM: begin
        byte_o = first ? OP_PGM_HI : OP_PGM_LO;
        len_o  = IDX_W'(2);
      end
      PH_FRM: begin
        byte_o    = first ? OP_FRAME : img_data_i;
        len_o     = IDX_W'(FRAME_BYTES + 1);
        is_data_o = !first;
      end
      PH_DIS: byte_o = OP_DISABLE;
      PH_REL: byte_o = OP_RELEASE;
      default: byte_o = OP_FILL;
    endcase
  end
endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
  import spi_cfg_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned FRAME_BYTES = 16,
  parameter int unsigned LEN_W       = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             partial_i,
  input  logic [LEN_W-1:0] img_len_i,
  input  logic             img_valid_i,
  input  logic [7:0]       img_data_i,
  output logic             img_ready_o,
  output logic             poll_req_o,
  output logic             poll_need_ready_o,
  input  logic             poll_ack_i,
  input  logic             poll_ok_i,
  output logic             spi_cs_o,
  output logic             spi_tx_valid_o,
  output logic [7:0]       spi_tx_data_o,
  input  logic             spi_tx_ready_i,
  input  logic [7:0]       spi_rx_data_i,
  output logic             prog_mode_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned SETTLE_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int unsigned OFF_W      = $clog2(FRAME_BYTES);
  localparam int unsigned FRM_W      = LEN_W - OFF_W;
  localparam int unsigned IDX_W      = $clog2(FRAME_BYTES + 2);

  step_e            step_q;
  phase_e           ph_q;
  logic [IDX_W-1:0] idx_q;
  logic             rb_nz_q, prog_q, done_q, err_q;

  logic [7:0]       tx_byte;
  logic [IDX_W-1:0] xfer_len;
  logic             is_data, fire, last_byte, bad_len;
  logic             frm_load, frm_dec, frm_zero, frm_last;
  logic             tmr_start, tmr_done;

  spi_cfg_cmd_rom #(.FRAME_BYTES(FRAME_BYTES), .IDX_W(IDX_W)) u_rom (
    .phase_i(ph_q), .idx_i(idx_q), .img_data_i(img_data_i),
    .byte_o(tx_byte), .len_o(xfer_len), .is_data_o(is_data)
  );

  spi_cfg_frame_ctr #(.W(FRM_W)) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(frm_load),
    .val_i(img_len_i[LEN_W-1:OFF_W]), .dec_i(frm_dec),
    .zero_o(frm_zero), .last_o(frm_last)
  );

  spi_cfg_settle_timer #(.CYCLES(SETTLE_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_start), .done_o(tmr_done)
  );

  assign bad_len           = |img_len_i[OFF_W-1:0];
  assign spi_cs_o          = (step_q == ST_XFER);
  assign spi_tx_valid_o    = spi_cs_o && (!is_data || img_valid_i);
  assign spi_tx_data_o     = tx_byte;
  assign img_ready_o       = spi_cs_o && is_data && spi_tx_ready_i;
  assign fire              = spi_tx_valid_o && spi_tx_ready_i;
  assign last_byte         = (idx_q == xfer_len - 1'b1);
  assign poll_req_o        = (step_q == ST_POLL);
  assign poll_need_ready_o = poll_req_o && (ph_q == PH_RD);
  assign frm_load          = (step_q == ST_IDLE) && start_i;
  assign frm_dec           = (step_q == ST_GAP) && (ph_q == PH_FRM);
  assign tmr_start         = (step_q == ST_GAP) && (ph_q == PH_DIS);
  assign prog_mode_o       = prog_q;
  assign done_o            = done_q;
  assign err_o             = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      ph_q    <= PH_EN;
      idx_q   <= '0;
      rb_nz_q <= 1'b0;
      prog_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (step_q)
        ST_IDLE: if (start_i) begin
          if (partial_i || bad_len) begin
            err_q <= 1'b1;
          end else begin
            step_q <= ST_POLL;
            ph_q   <= PH_EN;
          end
        end
        ST_POLL: if (poll_ack_i) begin
          if (poll_ok_i) begin
            step_q <= ST_XFER;
            idx_q  <= '0;
          end else begin
            step_q <= ST_IDLE;
            err_q  <= 1'b1;
            prog_q <= 1'b0;
          end
        end
        ST_XFER: if (fire) begin
          if (ph_q == PH_RD && idx_q != '0) rb_nz_q <= rb_nz_q | (|spi_rx_data_i);
          if (last_byte) step_q <= ST_GAP;
          else           idx_q  <= idx_q + 1'b1;
        end
        ST_GAP: begin
          step_q <= ST_POLL;
          unique case (ph_q)
            PH_EN: begin
              ph_q    <= PH_RD;
              rb_nz_q <= 1'b0;
            end
            PH_RD: begin
              if (rb_nz_q) begin
                step_q <= ST_IDLE;
                err_q  <= 1'b1;
              end else begin
                ph_q <= PH_PGM;
              end
            end
            PH_PGM: begin
              prog_q <= 1'b1;
              ph_q   <= frm_zero ? PH_DIS : PH_FRM;
            end
            PH_FRM: if (frm_last) ph_q <= PH_DIS;
            PH_DIS: step_q <= ST_SETTLE;
            PH_REL: begin
              step_q <= ST_IDLE;
              prog_q <= 1'b0;
              done_q <= 1'b1;
            end
            default: step_q <= ST_IDLE;
          endcase
        end
        ST_SETTLE: if (tmr_done) begin
          step_q <= ST_POLL;
          ph_q   <= PH_REL;
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_cs_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_o) |-> $past(poll_ack_i && poll_ok_i));
  a_r1_partial_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_IDLE && start_i && partial_i) |=> (err_o && !poll_req_o && !spi_cs_o));
  a_r2_len_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_IDLE && start_i && bad_len) |=> (err_o && !poll_req_o && !spi_cs_o));
  a_r4_ready_before_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_need_ready_o |-> !prog_mode_o);
  a_r8_data_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_ready_o |-> (spi_cs_o && prog_mode_o));
  a_r10_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r10_done_clears_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !prog_mode_o);
  a_r11_refusal_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_req_o && poll_ack_i && !poll_ok_i) |=>
      (err_o && !spi_cs_o && !poll_req_o && !prog_mode_o));
endmodule

// File: tb/spi_cfg_seq_tb_top.sv
module spi_cfg_seq_tb_top;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int unsigned SETTLE = CLK_HZ / 1000;
  localparam int unsigned LEN_W  = 24;

  typedef struct packed {
    logic        partial;
    logic        stall;
    logic [7:0]  fail_at;
    logic [15:0] len;
    logic [31:0] rd;
    logic        exp_err;
    logic [7:0]  exp_txn;
  } scen_t;

  localparam int NSC = 9;
  localparam scen_t SCN [NSC] = '{
    '{1'b1, 1'b0, 8'd255, 16'd32, 32'h0,          1'b1, 8'd0},
    '{1'b0, 1'b0, 8'd255, 16'd20, 32'h0,          1'b1, 8'd0},
    '{1'b0, 1'b0, 8'd255, 16'd0,  32'h0,          1'b0, 8'd5},
    '{1'b0, 1'b1, 8'd255, 16'd32, 32'h0,          1'b0, 8'd7},
    '{1'b0, 1'b0, 8'd255, 16'd48, 32'h0000_0100,  1'b1, 8'd2},
    '{1'b0, 1'b0, 8'd0,   16'd16, 32'h0,          1'b1, 8'd0},
    '{1'b0, 1'b0, 8'd3,   16'd32, 32'h0,          1'b1, 8'd3},
    '{1'b0, 1'b1, 8'd255, 16'd64, 32'h0,          1'b0, 8'd9},
    '{1'b0, 1'b1, 8'd255, 16'd16, 32'h8000_0000,  1'b1, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, partial = 1'b0;
  logic [LEN_W-1:0] img_len = '0;
  logic img_valid = 1'b0, img_ready;
  logic [7:0] img_data = '0;
  logic poll_req, poll_nr, poll_ack = 1'b0, poll_ok = 1'b0;
  logic cs, tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data, rx_data = '0;
  logic prog, done, err;

  always #4 clk = ~clk;

  spi_cfg_seq #(.CLK_HZ(CLK_HZ), .FRAME_BYTES(16), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .partial_i(partial),
    .img_len_i(img_len), .img_valid_i(img_valid), .img_data_i(img_data),
    .img_ready_o(img_ready), .poll_req_o(poll_req), .poll_need_ready_o(poll_nr),
    .poll_ack_i(poll_ack), .poll_ok_i(poll_ok), .spi_cs_o(cs),
    .spi_tx_valid_o(tx_valid), .spi_tx_data_o(tx_data), .spi_tx_ready_i(tx_ready),
    .spi_rx_data_i(rx_data), .prog_mode_o(prog), .done_o(done), .err_o(err)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // target model state
  int cyc = 0, cur_sc = 0, cur_len = 0, img_idx = 0, lat = 0;
  int poll_n = 0, txn_n = 0, blen = 0, grant_viol = 0, done_n = 0, err_n = 0;
  bit granted = 0, cs_prev = 0, stall = 0;
  int fail_at = 255;
  logic [31:0] rd_word = '0, nr_mask = '0;
  logic [7:0] byte_log [2048];
  int txn_beg [64], txn_len [64], rise_cyc [64], fall_cyc [64];
  bit prog_rise [64];

  function automatic logic [7:0] img_byte(int s, int n);
    return 8'(n * 7 + s * 13 + 5);
  endfunction

  function automatic int exp_tlen(int f, int j);
    if (j == 0) return 1;
    if (j == 1) return 5;
    if (j == 2) return 2;
    if (j < 3 + f) return 17;
    return 1;
  endfunction

  function automatic logic [7:0] exp_byte(int s, int f, int j, int k);
    if (j == 0) return 8'h0B;
    if (j == 1) return (k == 0) ? 8'h01 : 8'h00;
    if (j == 2) return (k == 0) ? 8'hAE : 8'h01;
    if (j < 3 + f) return (k == 0) ? 8'hEE : img_byte(s, (j - 3) * 16 + k - 1);
    if (j == 3 + f) return 8'h0C;
    return 8'h23;
  endfunction

  function automatic string txn_tag(int f, int j);
    if (j < 2) return "R5";
    if (j == 2) return "R7";
    if (j < 3 + f) return "R8";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // target, poller and image source model
  initial forever begin
    @(negedge clk);
    cyc++;
    tx_ready  = stall ? (cyc % 3 != 0) : 1'b1;
    img_valid = (img_idx < cur_len) && (stall ? (cyc % 4 != 1) : 1'b1);
    img_data  = img_byte(cur_sc, img_idx);
    poll_ack  = 1'b0;
    if (poll_req) begin
      if (lat == 2) begin
        poll_ack = 1'b1;
        poll_ok  = (poll_n != fail_at);
        if (poll_n < 32) nr_mask[poll_n] = poll_nr;
        if (poll_ok) granted = 1;
        poll_n++;
        lat = 0;
      end else lat++;
    end else lat = 0;
    #1;
    if (cs && !cs_prev) begin
      if (!granted) grant_viol++;
      granted = 0;
      txn_beg[txn_n]   = blen;
      rise_cyc[txn_n]  = cyc;
      prog_rise[txn_n] = prog;
    end
    if (!cs && cs_prev) begin
      txn_len[txn_n]  = blen - txn_beg[txn_n];
      fall_cyc[txn_n] = cyc;
      txn_n++;
    end
    cs_prev = cs;
    rx_data = 8'h00;
    if (cs && tx_valid && tx_ready) begin
      int k;
      k = blen - txn_beg[txn_n];
      if (txn_n == 1 && k >= 1 && k <= 4) rx_data = rd_word[8*(k-1) +: 8];
      byte_log[blen] = tx_data;
      blen++;
    end
    if (img_valid && img_ready) img_idx++;
    if (done) done_n++;
    if (err) err_n++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic run_scen(input int s);
    scen_t sc;
    int f, exp_polls, wait_n;
    string otag;
    sc = SCN[s];
    f  = int'(sc.len) / 16;
    @(negedge clk); #2;
    cur_sc = s; cur_len = int'(sc.len); img_idx = 0; stall = sc.stall;
    fail_at = int'(sc.fail_at); rd_word = sc.rd; nr_mask = '0;
    poll_n = 0; txn_n = 0; blen = 0; grant_viol = 0; done_n = 0; err_n = 0;
    granted = 0;
    start = 1'b1; partial = sc.partial; img_len = LEN_W'(sc.len);
    @(negedge clk); #2;
    start = 1'b0; partial = 1'b0;
    wait_n = 0;
    while (done_n == 0 && err_n == 0 && wait_n < 5000) begin
      @(negedge clk); wait_n++;
    end
    repeat (3) @(negedge clk);
    #2;

    if (sc.partial)             otag = "R1";
    else if (sc.len % 16 != 0)  otag = "R2";
    else if (sc.rd != 0)        otag = "R6";
    else if (sc.fail_at != 255) otag = "R11";
    else                        otag = "R10";
    chk(err_n == int'(sc.exp_err) && done_n == int'(!sc.exp_err), otag,
        err_n * 10 + done_n, sc.exp_err ? 10 : 1);
    chk(txn_n == int'(sc.exp_txn), (sc.rd != 0) ? "R6 txn count" : "R3 txn count",
        txn_n, int'(sc.exp_txn));
    exp_polls = (sc.fail_at != 255) ? int'(sc.fail_at) + 1 : int'(sc.exp_txn);
    chk(poll_n == exp_polls, "R3 poll count", poll_n, exp_polls);
    chk(grant_viol == 0, "R3 cs without grant", grant_viol, 0);
    chk(nr_mask == ((poll_n > 1) ? 32'h2 : 32'h0), "R4 ready-flag polls",
        int'(nr_mask), (poll_n > 1) ? 2 : 0);
    for (int j = 0; j < txn_n; j++) begin
      int bad, a, e;
      bad = 0; a = txn_len[j]; e = exp_tlen(f, j);
      if (txn_len[j] == exp_tlen(f, j)) begin
        for (int k = 0; k < txn_len[j]; k++)
          if (byte_log[txn_beg[j] + k] !== exp_byte(s, f, j, k) && bad == 0) begin
            bad = 1; a = int'(byte_log[txn_beg[j] + k]); e = int'(exp_byte(s, f, j, k));
          end
      end else bad = 1;
      chk(bad == 0, txn_tag(f, j), a, e);
    end
    if (txn_n > 1) chk(prog_rise[1] == 1'b0, "R7 mode low at read-back", int'(prog_rise[1]), 0);
    if (txn_n > 3) chk(prog_rise[3] == 1'b1, "R7 mode high after program cmd", int'(prog_rise[3]), 1);
    if (!sc.exp_err && txn_n >= 2)
      chk(rise_cyc[txn_n-1] - fall_cyc[txn_n-2] >= SETTLE, "R9 settle gap",
          rise_cyc[txn_n-1] - fall_cyc[txn_n-2], SETTLE);
    chk(prog == 1'b0 && cs == 1'b0 && poll_req == 1'b0,
        sc.exp_err ? "R11 idle after error" : "R10 mode cleared",
        int'({prog, cs, poll_req}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk({cs, poll_req, prog, done, err, img_ready, tx_valid} == '0, "R10 reset state",
        int'({cs, poll_req, prog, done, err, img_ready, tx_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int s = 0; s < NSC; s++) run_scen(s);
    // directed: start while partial and bad length both set
    @(negedge clk); #2;
    poll_n = 0; txn_n = 0; err_n = 0;
    start = 1'b1; partial = 1'b1; img_len = LEN_W'(7);
    @(negedge clk); #2;
    start = 1'b0; partial = 1'b0;
    chk(err == 1'b1 && poll_req == 1'b0, "R1 combined refusal", int'({err, poll_req}), 2);
    repeat (4) @(negedge clk);
    chk(poll_n == 0 && txn_n == 0, "R2 no traffic", poll_n + txn_n, 0);
    summary();
  end
endmodule